// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Engine

This block turns host register accesses at two offsets of a parallel-port window into handshaked byte cycles on a peripheral bus. Offset 3 runs address cycles and offset 4 runs data cycles. A cycle starts only if the stored control register, supplied from outside, holds the exact line pattern for the requested direction. A data access may be one, two or four bytes wide. It is broken into byte cycles that go out least significant byte first.

Each byte cycle raises an address or data strobe and holds it until the peripheral signals ready. If ready does not arrive within a programmable number of clocks, the rest of the access is abandoned and a sticky timeout flag is set. The flag appears as bit 0 of every status read at offset 1. Software clears it by writing offset 1 with bit 0 set. The host side uses a single-cycle request. The engine raises busy while it works and gives a one-cycle acknowledge with the read data.

Top module: `epp_cycle_gate`

## Requirements
- R1: A write at offset 3 or 4 runs byte cycles only when (ctrl_reg AND 0x2F) equals 0x04. Any other control value drops the write with no strobe, and the access is still acknowledged.
- R2: A read at offset 3 or 4 runs only when (ctrl_reg AND 0x2F) equals 0x24. A refused read returns all ones across its width (0xFF, 0xFFFF or 0xFFFFFFFF), with the bits above that width zero.
- R3: Offset 3 raises per_astb for exactly one byte cycle, whatever host_size holds. The byte written is host_wdata[7:0], and a read returns the byte in host_rdata[7:0]. per_astb and per_dstb are never high together.
- R4: At offset 4, host_size 0, 1 and 2 give 1, 2 and 4 byte cycles, and size 3 acts as size 2. Byte k of host_wdata goes out in cycle k, and the byte read in cycle k lands in host_rdata bits 8k+7:8k.
- R5: Within a byte cycle the strobe stays high until per_ready is sampled high. Between two byte cycles the strobe is low for at least one clock.
- R6: If per_ready is not seen within max(tmo_limit,1) strobe cycles, the strobe drops, no further bytes run and the timeout flag sets. An aborted read returns the bytes already completed, with 0xFF in the lanes that were not reached.
- R7: A status write (offset 1) with host_wdata[0]=1 clears the timeout flag. A status write with bit 0 clear leaves the flag unchanged.
- R8: A status read returns {stat_lines[7:1], timeout flag} in host_rdata[7:0].
- R9: After reset, host_busy, host_ack, per_astb and per_dstb are low and the timeout flag is 0.
- R10: host_busy is high from the cycle after an accepted request through the cycle of its one-cycle host_ack. A request made while busy is ignored.
- R11: Offsets 0, 2, 5, 6 and 7 are acknowledged without any strobe, and a read there returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | One-cycle access request, accepted when not busy |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_ofs | input | 3 | Register offset within the port window |
| host_size | input | 2 | Data width code: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data, valid while host_ack is high |
| host_busy | output | 1 | Access in progress |
| host_ack | output | 1 | One-cycle access completion |
| ctrl_reg | input | 8 | Stored control register value |
| stat_lines | input | 8 | External status lines |
| tmo_limit | input | TMO_W | Clocks allowed per byte cycle before abort (0 acts as 1) |
| per_astb | output | 1 | Address strobe |
| per_dstb | output | 1 | Data strobe |
| per_write | output | 1 | Direction of the current cycle, 1 = write |
| per_dout | output | 8 | Byte driven to the peripheral |
| per_din | input | 8 | Byte returned by the peripheral |
| per_ready | input | 1 | Peripheral completion of the current byte cycle |

## Verification
The bench builds the block with DATA_W = 32 and TMO_W = 4. The full set of four byte lanes is therefore in use, and every timeout limit fits in a handful of clocks. That makes it cheap to try all 256 control values, in both directions, against the two gate patterns. The peripheral model can delay ready by a chosen number of clocks. It can also stop answering after a chosen byte, so the bench sweeps latency across the timeout boundary and produces aborts partway through a multi-byte read.

// File: rtl/epp_pkg.sv
`timescale 1ns/1ps
package epp_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_STB  = 2'd1,
    SQ_GAP  = 2'd2,
    SQ_DONE = 2'd3
  } sq_state_t;

  typedef enum logic [1:0] {
    AK_OTHER  = 2'd0,
    AK_STATUS = 2'd1,
    AK_ADDR   = 2'd2,
    AK_DATA   = 2'd3
  } acc_kind_t;

  localparam logic [2:0] OFS_STATUS = 3'd1;
  localparam logic [2:0] OFS_ADDR   = 3'd3;
  localparam logic [2:0] OFS_DATA   = 3'd4;

  // direction bit 5 plus the four line bits 3..0
  localparam logic [7:0] GATE_MASK = 8'h2F;
  localparam logic [7:0] WR_MATCH  = 8'h04;
  localparam logic [7:0] RD_MATCH  = 8'h24;

  function automatic acc_kind_t decode_offset(input logic [2:0] ofs);
    case (ofs)
      OFS_STATUS: return AK_STATUS;
      OFS_ADDR:   return AK_ADDR;
      OFS_DATA:   return AK_DATA;
      default:    return AK_OTHER;
    endcase
  endfunction

endpackage

// File: rtl/epp_gate.sv
`timescale 1ns/1ps
module epp_gate
  import epp_pkg::*;
(
  input  logic [7:0] ctrl_i,
  output logic       wr_ok_o,
  output logic       rd_ok_o
);
  logic [7:0] masked;

  always_comb begin
    masked  = ctrl_i & GATE_MASK;
    wr_ok_o = (masked == WR_MATCH);
    rd_ok_o = (masked == RD_MATCH);
  end
endmodule

// File: rtl/epp_tmo_flag.sv
`timescale 1ns/1ps
module epp_tmo_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d, flag_en;

  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/epp_lane_plan.sv
`timescale 1ns/1ps
module epp_lane_plan
  import epp_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  acc_kind_t           kind_i,
  input  logic [1:0]          size_i,
  output logic [LIDX_W-1:0]   last_o,
  output logic [LANES*8-1:0]  fill_o
);
  localparam logic [7:0] LANES_B = 8'(LANES);

  logic [7:0] want;

  always_comb begin
    case (size_i)
      2'd0:    want = 8'd1;
      2'd1:    want = 8'd2;
      default: want = 8'd4;
    endcase
    if (kind_i != AK_DATA) want = 8'd1;
    if (want > LANES_B)    want = LANES_B;
    last_o = LIDX_W'(want - 8'd1);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_fill
    assign fill_o[g*8 +: 8] = (LIDX_W'(g) <= last_o) ? 8'hFF : 8'h00;
  end
endmodule

// File: rtl/epp_seq.sv
`timescale 1ns/1ps
module epp_seq
  import epp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TMO_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [2:0]        ofs_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_ok_i,
  input  logic              rd_ok_i,
  input  logic [7:0]        stat_i,
  input  logic              flag_i,
  input  logic [TMO_W-1:0]  tmo_limit_i,
  input  logic              ready_i,
  input  logic [7:0]        din_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              ack_o,
  output logic              astb_o,
  output logic              dstb_o,
  output logic              write_o,
  output logic [7:0]        dout_o,
  output logic              tmo_set_o,
  output logic              flag_clr_o
);
  localparam int LANES  = DATA_W / 8;
  localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  sq_state_t         st_q, st_d;
  logic [LIDX_W-1:0] idx_q, idx_d, last_q, last_d;
  logic [TMO_W-1:0]  cnt_q, cnt_d, lim_m1;
  logic [DATA_W-1:0] buf_q, buf_d;
  logic              wr_q, wr_d, addr_q, addr_d;
  logic              ctx_en, buf_en, cnt_en, idx_en;
  acc_kind_t         kind;
  logic [LIDX_W-1:0] plan_last;
  logic [DATA_W-1:0] plan_fill;
  logic              go;
  logic              unused_stat_bit;

  assign unused_stat_bit = stat_i[0];

  assign kind = decode_offset(ofs_i);

  epp_lane_plan #(.LANES(LANES), .LIDX_W(LIDX_W)) u_plan (
    .kind_i (kind),
    .size_i (size_i),
    .last_o (plan_last),
    .fill_o (plan_fill)
  );

  assign lim_m1 = (tmo_limit_i == '0) ? '0 : tmo_limit_i - 1'b1;

  always_comb begin
    st_d       = st_q;
    idx_d      = idx_q;
    last_d     = last_q;
    cnt_d      = cnt_q;
    buf_d      = buf_q;
    wr_d       = wr_q;
    addr_d     = addr_q;
    ctx_en     = 1'b0;
    buf_en     = 1'b0;
    cnt_en     = 1'b0;
    idx_en     = 1'b0;
    tmo_set_o  = 1'b0;
    flag_clr_o = 1'b0;
    go         = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (req_i) begin
          ctx_en = 1'b1;
          wr_d   = wr_i;
          addr_d = (kind == AK_ADDR);
          last_d = plan_last;
          idx_en = 1'b1;
          idx_d  = '0;
          cnt_en = 1'b1;
          cnt_d  = '0;
          st_d   = SQ_DONE;
          case (kind)
            AK_STATUS: begin
              flag_clr_o = wr_i & wdata_i[0];
              if (!wr_i) begin
                buf_en = 1'b1;
                buf_d  = DATA_W'({stat_i[7:1], flag_i});
              end
            end
            AK_ADDR, AK_DATA: begin
              go     = wr_i ? wr_ok_i : rd_ok_i;
              buf_en = 1'b1;
              buf_d  = wr_i ? wdata_i : plan_fill;
              if (go) st_d = SQ_STB;
            end
            default: begin
              buf_en = 1'b1;
              buf_d  = DATA_W'(8'hFF);
            end
          endcase
        end
      end
      SQ_STB: begin
        if (ready_i) begin
          if (!wr_q) begin
            buf_en = 1'b1;
            buf_d[{idx_q, 3'b000} +: 8] = din_i;
          end
          if (idx_q == last_q) begin
            st_d = SQ_DONE;
          end else begin
            idx_en = 1'b1;
            idx_d  = idx_q + 1'b1;
            st_d   = SQ_GAP;
          end
        end else if (cnt_q >= lim_m1) begin
          tmo_set_o = 1'b1;
          st_d      = SQ_DONE;
        end else begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q + 1'b1;
        end
      end
      SQ_GAP: begin
        cnt_en = 1'b1;
        cnt_d  = '0;
        st_d   = SQ_STB;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      addr_q <= 1'b0;
      last_q <= '0;
    end else if (ctx_en) begin
      wr_q   <= wr_d;
      addr_q <= addr_d;
      last_q <= last_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      buf_q <= '0;
    else if (buf_en) buf_q <= buf_d;
  end

  assign busy_o  = (st_q != SQ_IDLE);
  assign ack_o   = (st_q == SQ_DONE);
  assign astb_o  = (st_q == SQ_STB) &  addr_q;
  assign dstb_o  = (st_q == SQ_STB) & ~addr_q;
  assign write_o = wr_q;
  assign dout_o  = buf_q[{idx_q, 3'b000} +: 8];
  assign rdata_o = buf_q;
endmodule

// File: rtl/epp_cycle_gate.sv
`timescale 1ns/1ps
module epp_cycle_gate #(
  parameter int DATA_W = 32,
  parameter int TMO_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [2:0]        host_ofs,
  input  logic [1:0]        host_size,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_busy,
  output logic              host_ack,
  input  logic [7:0]        ctrl_reg,
  input  logic [7:0]        stat_lines,
  input  logic [TMO_W-1:0]  tmo_limit,
  output logic              per_astb,
  output logic              per_dstb,
  output logic              per_write,
  output logic [7:0]        per_dout,
  input  logic [7:0]        per_din,
  input  logic              per_ready
);
  logic wr_ok, rd_ok, tmo_set, flag_clr, tmo_flag;

  epp_gate u_gate (
    .ctrl_i  (ctrl_reg),
    .wr_ok_o (wr_ok),
    .rd_ok_o (rd_ok)
  );

  epp_tmo_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (tmo_set),
    .clr_i  (flag_clr),
    .flag_o (tmo_flag)
  );

  epp_seq #(.DATA_W(DATA_W), .TMO_W(TMO_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (host_req),
    .wr_i        (host_wr),
    .ofs_i       (host_ofs),
    .size_i      (host_size),
    .wdata_i     (host_wdata),
    .wr_ok_i     (wr_ok),
    .rd_ok_i     (rd_ok),
    .stat_i      (stat_lines),
    .flag_i      (tmo_flag),
    .tmo_limit_i (tmo_limit),
    .ready_i     (per_ready),
    .din_i       (per_din),
    .rdata_o     (host_rdata),
    .busy_o      (host_busy),
    .ack_o       (host_ack),
    .astb_o      (per_astb),
    .dstb_o      (per_dstb),
    .write_o     (per_write),
    .dout_o      (per_dout),
    .tmo_set_o   (tmo_set),
    .flag_clr_o  (flag_clr)
  );
endmodule

// File: rtl/epp_cycle_gate_chk.sv
`timescale 1ns/1ps
module epp_cycle_gate_chk #(
  parameter int DATA_W = 32,
  parameter int TMO_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_req,
  input logic              host_wr,
  input logic [2:0]        host_ofs,
  input logic [DATA_W-1:0] host_wdata,
  input logic              host_busy,
  input logic              host_ack,
  input logic [7:0]        ctrl_reg,
  input logic [TMO_W-1:0]  tmo_limit,
  input logic              per_astb,
  input logic              per_dstb,
  input logic              per_ready,
  input logic              flag_i
);
  logic             stb;
  logic [TMO_W:0]   run_q;
  logic [TMO_W-1:0] lim_eff;

  assign stb     = per_astb | per_dstb;
  assign lim_eff = (tmo_limit == '0) ? TMO_W'(1) : tmo_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 run_q <= '0;
    else if (stb && !per_ready) run_q <= run_q + 1'b1;
    else                        run_q <= '0;
  end

  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({per_astb, per_dstb}));

  assert_ack_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |-> host_busy);

  assert_ack_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> !host_ack);

  assert_refused_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_busy && host_wr && host_ofs == 3'd4 &&
     (ctrl_reg & 8'h2F) != 8'h04) |=> !(per_astb || per_dstb));

  assert_refused_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_busy && !host_wr && host_ofs == 3'd4 &&
     (ctrl_reg & 8'h2F) != 8'h24) |=> !(per_astb || per_dstb));

  assert_strobe_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> (run_q < {1'b0, lim_eff}));

  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_i) |-> $past(per_astb || per_dstb));

  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_i) |-> $past(host_req && !host_busy && host_wr &&
                             host_ofs == 3'd1 && host_wdata[0]));
endmodule

bind epp_cycle_gate epp_cycle_gate_chk #(.DATA_W(DATA_W), .TMO_W(TMO_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_req   (host_req),
  .host_wr    (host_wr),
  .host_ofs   (host_ofs),
  .host_wdata (host_wdata),
  .host_busy  (host_busy),
  .host_ack   (host_ack),
  .ctrl_reg   (ctrl_reg),
  .tmo_limit  (tmo_limit),
  .per_astb   (per_astb),
  .per_dstb   (per_dstb),
  .per_ready  (per_ready),
  .flag_i     (tmo_flag)
);

// File: tb/epp_cycle_gate_tb.sv
`timescale 1ns/1ps
module epp_cycle_gate_tb;
  localparam int DATA_W = 32;
  localparam int TMO_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req, wr;
  logic [2:0]        ofs;
  logic [1:0]        size;
  logic [DATA_W-1:0] wdata, rdata;
  logic              busy, ack;
  logic [7:0]        ctrl, stat;
  logic [TMO_W-1:0]  lim;
  logic              astb, dstb, pwrite, pready;
  logic [7:0]        dout, din;

  int nchk = 0;
  int nerr = 0;

  // peripheral model controls and observation
  logic       clr;
  int         lat, resp_n;
  logic [3:0] nlog;
  logic [7:0] rises, stb_cyc, run, log_d [0:7];
  logic       log_a [0:7];
  logic       prev;

  always #4 clk = ~clk;

  epp_cycle_gate #(.DATA_W(DATA_W), .TMO_W(TMO_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_req(req), .host_wr(wr), .host_ofs(ofs),
    .host_size(size), .host_wdata(wdata), .host_rdata(rdata), .host_busy(busy),
    .host_ack(ack), .ctrl_reg(ctrl), .stat_lines(stat), .tmo_limit(lim),
    .per_astb(astb), .per_dstb(dstb), .per_write(pwrite), .per_dout(dout),
    .per_din(din), .per_ready(pready)
  );

  assign pready = (astb | dstb) && (int'(nlog) < resp_n) && (int'(run) >= lat);
  assign din    = 8'hA0 + {4'h0, nlog};

  always @(posedge clk) begin
    if (clr) begin
      nlog <= 0; rises <= 0; stb_cyc <= 0; run <= 0; prev <= 0;
    end else begin
      prev <= astb | dstb;
      if (astb | dstb) begin
        stb_cyc <= stb_cyc + 1;
        if (!prev) rises <= rises + 1;
      end
      run <= ((astb | dstb) && !pready) ? run + 1 : 8'd0;
      if ((astb | dstb) && pready && nlog < 8) begin
        log_d[nlog[2:0]] <= dout;
        log_a[nlog[2:0]] <= astb;
        nlog <= nlog + 1;
      end
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [2:0] o, input logic [1:0] s,
                     input logic [31:0] d, output logic [31:0] r);
    int waitc;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    req = 1'b1; wr = w; ofs = o; size = s; wdata = d;
    @(negedge clk); req = 1'b0;
    waitc = 0;
    while (!ack && waitc < 200) begin @(negedge clk); waitc++; end
    if (!ack) chk("R10 ack missing", 32'(ack), 32'd1);
    r = rdata;
    @(negedge clk);
  endtask

  function automatic int nbytes(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] ones_w(input int n);
    return (n >= 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * n)) - 1);
  endfunction

  logic [31:0] r;
  logic [31:0] exp_v;

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL R10 watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = 0; wr = 0; ofs = 0; size = 0; wdata = 0;
    ctrl = 8'hCC; stat = 8'h5A; lim = 4'd4; clr = 1'b1; lat = 0; resp_n = 8;
    repeat (3) @(negedge clk);
    chk("R9 busy", 32'(busy), 0);
    chk("R9 ack", 32'(ack), 0);
    chk("R9 strobes", 32'({astb, dstb}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 busy after release", 32'(busy), 0);

    // R9 / R8: flag clear after reset, bits 7:1 from the lines
    acc(0, 3'd1, 0, 0, r); chk("R9 R8 status", r, 32'h5A);
    stat = 8'hA5;
    acc(0, 3'd1, 0, 0, r); chk("R8 status", r, 32'hA4);

    // R1 / R2: full sweep of control values
    for (int c = 0; c < 256; c++) begin
      ctrl = 8'(c);
      acc(1, 3'd4, 0, 32'(c), r);
      chk($sformatf("R1 gate ctrl=%02h", c), 32'(nlog),
          ((c & 8'h2F) == 8'h04) ? 32'd1 : 32'd0);
      acc(0, 3'd4, 0, 0, r);
      chk($sformatf("R2 gate ctrl=%02h", c), 32'(nlog),
          ((c & 8'h2F) == 8'h24) ? 32'd1 : 32'd0);
      chk($sformatf("R2 data ctrl=%02h", c), r,
          ((c & 8'h2F) == 8'h24) ? 32'hA0 : 32'hFF);
    end

    // R4 / R5: widths and byte order
    for (int s = 0; s < 4; s++) begin
      ctrl = 8'h04;
      acc(1, 3'd4, 2'(s), 32'h4433_2211, r);
      chk("R4 write count", 32'(nlog), 32'(nbytes(2'(s))));
      chk("R5 strobe pulses", 32'(rises), 32'(nbytes(2'(s))));
      for (int k = 0; k < nbytes(2'(s)); k++)
        chk("R4 write byte order", 32'(log_d[k]), 32'(8'h11 * (k + 1)));
      acc(0, 3'd4, 2'(s), 0, r);
      chk("R2 refused wide read", r, ones_w(nbytes(2'(s))));
      ctrl = 8'h24;
      acc(0, 3'd4, 2'(s), 0, r);
      exp_v = 0;
      for (int k = 0; k < nbytes(2'(s)); k++) exp_v |= 32'(8'hA0 + k) << (8 * k);
      chk("R4 read assembly", r, exp_v);
      chk("R5 read pulses", 32'(rises), 32'(nbytes(2'(s))));
    end

    // R3: address cycles single byte
    ctrl = 8'h04;
    acc(1, 3'd3, 2'd2, 32'hDEAD_BE77, r);
    chk("R3 addr count", 32'(nlog), 1);
    chk("R3 addr strobe", 32'(log_a[0]), 1);
    chk("R3 addr byte", 32'(log_d[0]), 32'h77);
    ctrl = 8'h24;
    acc(0, 3'd3, 2'd2, 0, r);
    chk("R3 addr read", r, 32'hA0);
    chk("R3 addr read strobe", 32'(log_a[0]), 1);

    // R5 / R6 / R7: latency sweep across the limit
    ctrl = 8'h04; lim = 4'd4;
    for (int l = 0; l < 6; l++) begin
      lat = l;
      acc(1, 3'd4, 2'd1, 32'h0000_6655, r);
      if (l <= 3) begin
        chk("R5 slow ready ok", 32'(nlog), 2);
        chk("R5 strobe held", 32'(stb_cyc), 32'(2 * (l + 1)));
        acc(0, 3'd1, 0, 0, r); chk("R6 no flag", 32'(r[0]), 0);
      end else begin
        chk("R6 abort count", 32'(nlog), 0);
        chk("R6 strobe cycles", 32'(stb_cyc), 4);
        acc(0, 3'd1, 0, 0, r); chk("R6 flag set", 32'(r[0]), 1);
        acc(1, 3'd1, 0, 32'hFE, r);
        acc(0, 3'd1, 0, 0, r); chk("R7 bit0 clear keeps flag", 32'(r[0]), 1);
        acc(1, 3'd1, 0, 32'h01, r);
        acc(0, 3'd1, 0, 0, r); chk("R7 flag cleared", 32'(r[0]), 0);
      end
    end

    // R6: limit 0 acts as 1
    lim = 4'd0; lat = 0;
    acc(1, 3'd4, 0, 32'h12, r); chk("R6 lim0 ok", 32'(nlog), 1);
    lat = 1;
    acc(1, 3'd4, 0, 32'h12, r);
    chk("R6 lim0 abort", 32'(stb_cyc), 1);
    acc(1, 3'd1, 0, 32'h01, r);

    // R6: partial read abort
    ctrl = 8'h24; lim = 4'd3; lat = 0; resp_n = 2;
    acc(0, 3'd4, 2'd2, 0, r);
    chk("R6 partial read", r, 32'hFFFF_A1A0);
    chk("R6 partial count", 32'(nlog), 2);
    acc(0, 3'd1, 0, 0, r); chk("R6 partial flag", 32'(r[0]), 1);
    resp_n = 8;

    // R10: request while busy is ignored
    ctrl = 8'h04; lim = 4'd4; lat = 2;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    req = 1; wr = 1; ofs = 3'd4; size = 2'd2; wdata = 32'hDDCC_BBAA;
    @(negedge clk); req = 0;
    chk("R10 busy after request", 32'(busy), 1);
    @(negedge clk);
    req = 1; ofs = 3'd1; wdata = 32'h1;
    @(negedge clk); req = 0;
    for (int i = 0; i < 100 && !ack; i++) @(negedge clk);
    chk("R10 busy at ack", 32'(busy), 1);
    @(negedge clk);
    chk("R10 ack single", 32'(ack), 0);
    repeat (3) @(negedge clk);
    chk("R10 no second ack", 32'(ack), 0);
    chk("R10 all bytes", 32'(nlog), 4);
    chk("R10 byte3", 32'(log_d[3]), 32'hDD);
    acc(0, 3'd1, 0, 0, r); chk("R10 ignored status write", 32'(r[0]), 1);
    acc(1, 3'd1, 0, 32'h01, r);
    lat = 0;

    // R11: other offsets
    ctrl = 8'h24;
    for (int o = 0; o < 8; o++) begin
      if (o == 1 || o == 3 || o == 4) continue;
      acc(0, 3'(o), 2'd2, 0, r);
      chk("R11 other read", r, 32'hFF);
      chk("R11 no strobe", 32'(stb_cyc), 0);
    end

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule